// File: doc/BRIEF.md
# Serial FPGA Configuration Sequencer

This block is the master side of a slave-serial configuration link. It loads a bitstream into a target device. A start pulse begins a load. The block pulls the target's active-low program pin down and waits for the target's init pin to acknowledge by going low. It then releases the program pin and waits for init to come back high. Next it confirms that the target's done pin is still low and waits out a programming latency. Only after that does it take bitstream bytes from a valid/ready byte stream and shift each one out on a divided serial clock and a data line.

After the byte flagged as last, the block keeps the serial clock running by sending all-ones bytes. It checks the done pin after each of them, and once done is high it sends one final all-ones byte. A status interface reports busy, a success flag and a two-bit error code, and a separate flag marks a timeout that happened while waiting for init to rise. Partial-reconfiguration requests are refused before any pin moves.

A parameter selects whether an init pin is wired. Without one, the block holds program low for a fixed cycle count and skips the wait for init to rise. All timeouts and delays are cycle counts, which are parameters or an input.

Top module: `fpga_serial_loader`

## Requirements
- R1: Out of reset, cfg_prog_n is 1, cfg_cclk is 0, s_ready is 0, busy is 0, done_ok is 0 and err_code is 0 (none).
- R2: A start with partial set returns err_code 3 (invalid) while busy stays 0, and cfg_prog_n never goes low.
- R3: After an accepted start, cfg_prog_n stays low until init is seen low. If init stays high for INIT_TMO_CYC cycles, cfg_prog_n is released and err_code becomes 1 (timeout) with err_init_rise 0.
- R4: If init does not return high within INIT_TMO_CYC cycles after program is released, the load ends with err_code 1 and err_init_rise 1.
- R5: If done is high once init has risen, the load ends with err_code 2 (I/O) and no serial clock pulse is produced.
- R6: At least LATENCY_CYC cycles pass between init going high and the first rising edge of cfg_cclk.
- R7: Each byte is sent most significant bit first, one bit per cfg_cclk rising edge. Rising edges within a byte are 2*CLK_DIV cycles apart, and cfg_din changes only while cfg_cclk is low.
- R8: If done is already high after the last data byte, exactly one 0xFF byte follows, then done_ok becomes 1 with err_code 0.
- R9: If done is low after the last data byte, 0xFF bytes are sent and done is checked after each one. When done is seen high, exactly one more 0xFF byte is sent before done_ok is set.
- R10: If done stays low for cmpl_tmo_cyc cycles after the last data byte, the load ends with err_code 1 and err_init_rise 0, and only 0xFF bytes follow the data.
- R11: err_code, err_init_rise and done_ok hold their value until the next start pulse. A start pulse while busy is ignored.
- R12: s_ready is high only while waiting for a data byte, never while cfg_cclk is high or program is asserted. Each handshake consumes exactly one byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a load |
| partial | input | 1 | Request is a partial reconfiguration (refused) |
| cmpl_tmo_cyc | input | CT_W | Cycles allowed for done to rise after the data |
| s_data | input | BYTE_W | Bitstream byte |
| s_valid | input | 1 | s_data holds a byte |
| s_last | input | 1 | Byte is the final bitstream byte |
| s_ready | output | 1 | Block accepts a byte this cycle |
| cfg_prog_n | output | 1 | Active-low program pin to the target |
| cfg_init_n | input | 1 | Target init pin (low while clearing) |
| cfg_done | input | 1 | Target done pin |
| cfg_cclk | output | 1 | Serial configuration clock |
| cfg_din | output | 1 | Serial configuration data |
| busy | output | 1 | Load in progress |
| done_ok | output | 1 | Last load finished with done high |
| err_code | output | 2 | 0 none, 1 timeout, 2 I/O, 3 invalid |
| err_init_rise | output | 1 | Timeout happened waiting for init to rise |

## Verification
The assertions watch the properties that hold on every cycle. Data moves only while the serial clock is low, no clock pulse happens while program is asserted, s_ready stays out of the clocked and program phases, status is clean when busy rises and stays unchanged while idle, and success never comes with an error code. Only the bench's scenarios can show the rest: that the byte order and trailer counts are exact, that the latency is respected, and that each failure path (init stuck high, init stuck low, done early, done never) ends with the right code and leaves program released.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

   typedef enum logic [1:0] {
      ERR_NONE    = 2'd0,
      ERR_TIMEOUT = 2'd1,
      ERR_IO      = 2'd2,
      ERR_INVALID = 2'd3
   } cfgld_err_e;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_PROG_LOW,
      ST_INIT_HIGH,
      ST_DONE_CHK,
      ST_LATENCY,
      ST_DATA_REQ,
      ST_DATA_SHIFT,
      ST_TAIL_CHK,
      ST_TAIL_SHIFT,
      ST_FINAL_SHIFT
   } cfgld_state_e;

   function automatic int max_int(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/cfgld_sync.sv
module cfgld_sync #(
   parameter int W      = 2,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   input  logic [W-1:0] rst_val,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      initial $fatal(1, "cfgld_sync needs at least two stages");
   end

   for (genvar b = 0; b < W; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= {STAGES{rst_val[b]}};
         else        chain <= {chain[STAGES-2:0], d[b]};
      end
      assign q[b] = chain[STAGES-1];
   end
endmodule

// File: rtl/cfgld_timer.sv
module cfgld_timer #(
   parameter int TW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [TW-1:0] load_val,
   output logic          expired
);
   logic [TW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '0;
      else if (load)        cnt <= load_val;
      else if (cnt != '0)   cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);
endmodule

// File: rtl/cfgld_shifter.sv
module cfgld_shifter #(
   parameter int CLK_DIV = 4,
   parameter int W       = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] byte_in,
   output logic         busy,
   output logic         byte_done,
   output logic         sclk,
   output logic         sdo
);
   localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
   localparam int BW = $clog2(W + 1);
   localparam logic [DW-1:0] DIV_LAST = DW'(CLK_DIV - 1);

   logic [W-1:0]  sr;
   logic [BW-1:0] bits_left;
   logic [DW-1:0] div_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr        <= '0;
         bits_left <= '0;
         div_cnt   <= '0;
         busy      <= 1'b0;
         byte_done <= 1'b0;
         sclk      <= 1'b0;
         sdo       <= 1'b1;
      end else begin
         byte_done <= 1'b0;
         if (load && !busy) begin
            sdo       <= byte_in[W-1];
            sr        <= byte_in << 1;
            bits_left <= BW'(W - 1);
            div_cnt   <= '0;
            busy      <= 1'b1;
            sclk      <= 1'b0;
         end else if (busy) begin
            if (div_cnt == DIV_LAST) begin
               div_cnt <= '0;
               if (!sclk) begin
                  sclk <= 1'b1;
               end else begin
                  sclk <= 1'b0;
                  if (bits_left == '0) begin
                     busy      <= 1'b0;
                     byte_done <= 1'b1;
                  end else begin
                     sdo       <= sr[W-1];
                     sr        <= sr << 1;
                     bits_left <= bits_left - 1'b1;
                  end
               end
            end else begin
               div_cnt <= div_cnt + 1'b1;
            end
         end
      end
   end

   // R7: data moves only in the low half of the serial clock
   p_din_low_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sdo) |-> !sclk);
   // R7: a byte finishes with the clock back low
   p_byte_end_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
      byte_done |-> !sclk && !busy);
endmodule

// File: rtl/fpga_serial_loader.sv
module fpga_serial_loader
   import cfgld_pkg::*;
#(
   parameter int CLK_DIV      = 4,
   parameter int HAS_INIT     = 1,
   parameter int INIT_TMO_CYC = 200_000_000,
   parameter int LATENCY_CYC  = 1_500_000,
   parameter int PROG_MIN_CYC = 100,
   parameter int CT_W         = 32,
   parameter int SYNC_STAGES  = 2,
   parameter int BYTE_W       = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              partial,
   input  logic [CT_W-1:0]   cmpl_tmo_cyc,
   input  logic [BYTE_W-1:0] s_data,
   input  logic              s_valid,
   input  logic              s_last,
   output logic              s_ready,
   output logic              cfg_prog_n,
   input  logic              cfg_init_n,
   input  logic              cfg_done,
   output logic              cfg_cclk,
   output logic              cfg_din,
   output logic              busy,
   output logic              done_ok,
   output logic [1:0]        err_code,
   output logic              err_init_rise
);
   localparam int TW_I = $clog2(INIT_TMO_CYC + 1);
   localparam int TW_L = $clog2(LATENCY_CYC + 1);
   localparam int TW_P = $clog2(PROG_MIN_CYC + 1);
   localparam int TW   = max_int(max_int(TW_I, TW_L), max_int(TW_P, CT_W));

   if (CLK_DIV < 2) begin : g_bad_div
      initial $fatal(1, "CLK_DIV must be at least 2");
   end
   if (BYTE_W < 2) begin : g_bad_width
      initial $fatal(1, "BYTE_W must be at least 2");
   end
   if (HAS_INIT != 0 && HAS_INIT != 1) begin : g_bad_init
      initial $fatal(1, "HAS_INIT must be 0 or 1");
   end

   // pin synchronisers: bit 1 init, bit 0 done
   logic [1:0] pins_s;
   logic       init_s, done_s;
   cfgld_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d       ({cfg_init_n, cfg_done}),
      .rst_val (2'b10),
      .q       (pins_s)
   );
   assign init_s = pins_s[1];
   assign done_s = pins_s[0];

   logic          tmr_ld, tmr_zero;
   logic [TW-1:0] tmr_val;
   cfgld_timer #(.TW(TW)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_ld),
      .load_val (tmr_val),
      .expired  (tmr_zero)
   );

   logic              sh_load, sh_busy, sh_done;
   logic [BYTE_W-1:0] sh_byte;
   cfgld_shifter #(.CLK_DIV(CLK_DIV), .W(BYTE_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (sh_load),
      .byte_in   (sh_byte),
      .busy      (sh_busy),
      .byte_done (sh_done),
      .sclk      (cfg_cclk),
      .sdo       (cfg_din)
   );

   // init pin present or replaced by a fixed delay
   logic          lo_met, lo_fail, hi_met;
   logic [TW-1:0] lo_load;
   if (HAS_INIT != 0) begin : g_init_pin
      assign lo_load = TW'(INIT_TMO_CYC);
      assign lo_met  = !init_s;
      assign lo_fail = init_s && tmr_zero;
      assign hi_met  = init_s;
   end else begin : g_init_strap
      assign lo_load = TW'(PROG_MIN_CYC);
      assign lo_met  = tmr_zero;
      assign lo_fail = 1'b0;
      assign hi_met  = 1'b1;
   end

   cfgld_state_e state, nxt;
   cfgld_err_e   err_q, err_nxt;
   logic         last_q;
   logic         stat_clr, set_err, set_rise, set_ok, prog_lo, prog_hi;

   always_comb begin
      nxt      = state;
      tmr_ld   = 1'b0;
      tmr_val  = '0;
      sh_load  = 1'b0;
      sh_byte  = '1;
      stat_clr = 1'b0;
      set_err  = 1'b0;
      err_nxt  = ERR_NONE;
      set_rise = 1'b0;
      set_ok   = 1'b0;
      prog_lo  = 1'b0;
      prog_hi  = 1'b0;
      s_ready  = 1'b0;
      unique case (state)
         ST_IDLE: if (start) begin
            stat_clr = 1'b1;
            if (partial) begin
               set_err = 1'b1;
               err_nxt = ERR_INVALID;
            end else begin
               prog_lo = 1'b1;
               tmr_ld  = 1'b1;
               tmr_val = lo_load;
               nxt     = ST_PROG_LOW;
            end
         end
         ST_PROG_LOW: if (lo_met) begin
            prog_hi = 1'b1;
            tmr_ld  = 1'b1;
            tmr_val = TW'(INIT_TMO_CYC);
            nxt     = ST_INIT_HIGH;
         end else if (lo_fail) begin
            prog_hi = 1'b1;
            set_err = 1'b1;
            err_nxt = ERR_TIMEOUT;
            nxt     = ST_IDLE;
         end
         ST_INIT_HIGH: if (hi_met) begin
            nxt = ST_DONE_CHK;
         end else if (tmr_zero) begin
            set_err  = 1'b1;
            err_nxt  = ERR_TIMEOUT;
            set_rise = 1'b1;
            nxt      = ST_IDLE;
         end
         ST_DONE_CHK: if (done_s) begin
            set_err = 1'b1;
            err_nxt = ERR_IO;
            nxt     = ST_IDLE;
         end else begin
            tmr_ld  = 1'b1;
            tmr_val = TW'(LATENCY_CYC);
            nxt     = ST_LATENCY;
         end
         ST_LATENCY: if (tmr_zero) nxt = ST_DATA_REQ;
         ST_DATA_REQ: begin
            s_ready = !sh_busy;
            sh_byte = s_data;
            if (s_valid && !sh_busy) begin
               sh_load = 1'b1;
               nxt     = ST_DATA_SHIFT;
            end
         end
         ST_DATA_SHIFT: if (sh_done) begin
            if (last_q) begin
               tmr_ld  = 1'b1;
               tmr_val = TW'(cmpl_tmo_cyc);
               nxt     = ST_TAIL_CHK;
            end else begin
               nxt = ST_DATA_REQ;
            end
         end
         ST_TAIL_CHK: if (done_s) begin
            sh_load = 1'b1;
            nxt     = ST_FINAL_SHIFT;
         end else if (tmr_zero) begin
            set_err = 1'b1;
            err_nxt = ERR_TIMEOUT;
            nxt     = ST_IDLE;
         end else begin
            sh_load = 1'b1;
            nxt     = ST_TAIL_SHIFT;
         end
         ST_TAIL_SHIFT:  if (sh_done) nxt = ST_TAIL_CHK;
         ST_FINAL_SHIFT: if (sh_done) begin
            set_ok = 1'b1;
            nxt    = ST_IDLE;
         end
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state         <= ST_IDLE;
         err_q         <= ERR_NONE;
         err_init_rise <= 1'b0;
         done_ok       <= 1'b0;
         cfg_prog_n    <= 1'b1;
         last_q        <= 1'b0;
      end else begin
         state <= nxt;
         if (stat_clr) begin
            err_q         <= ERR_NONE;
            err_init_rise <= 1'b0;
            done_ok       <= 1'b0;
         end
         if (set_err)  err_q         <= err_nxt;
         if (set_rise) err_init_rise <= 1'b1;
         if (set_ok)   done_ok       <= 1'b1;
         if (prog_lo)  cfg_prog_n    <= 1'b0;
         if (prog_hi)  cfg_prog_n    <= 1'b1;
         if (sh_load && state == ST_DATA_REQ) last_q <= s_last;
      end
   end

   assign busy     = (state != ST_IDLE);
   assign err_code = err_q;

   // R5: no serial clock pulse while program is asserted
   p_cclk_needs_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_cclk |-> cfg_prog_n);
   // R3: program is only held low during a load
   p_prog_low_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_prog_n |-> busy);
   // R12: byte requests stay out of the clocked and program phases
   p_ready_phase_r12: assert property (@(posedge clk) disable iff (!rst_n)
      s_ready |-> !cfg_cclk && cfg_prog_n && busy);
   // R11: a new load starts with clean status
   p_status_clean_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> err_code == ERR_NONE && !done_ok && !err_init_rise);
   // R11: status holds while idle with no start
   p_status_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(err_code) && $stable(done_ok) && $stable(err_init_rise));
   // R8: success never carries an error code
   p_ok_no_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_ok |-> err_code == ERR_NONE);
endmodule

// File: tb/fpga_serial_loader_bench.sv
module fpga_serial_loader_bench;
   localparam int DIV   = 3;
   localparam int LAT   = 60;
   localparam int ITMO  = 200;
   localparam int PMIN  = 20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0, partial = 1'b0;
   logic [31:0] cmpl_tmo = 32'd5000;
   logic [7:0]  s_data = '0;
   logic        s_valid = 1'b0, s_last = 1'b0;
   logic        s_ready, cfg_prog_n, cfg_cclk, cfg_din, busy, done_ok, err_init_rise;
   logic [1:0]  err_code;
   logic        init_n = 1'b1, done_pin = 1'b0;

   always #2.5 clk = ~clk;

   fpga_serial_loader #(
      .CLK_DIV(DIV), .HAS_INIT(1), .INIT_TMO_CYC(ITMO), .LATENCY_CYC(LAT),
      .PROG_MIN_CYC(PMIN), .CT_W(32), .SYNC_STAGES(2), .BYTE_W(8)
   ) u_fpga_serial_loader (
      .clk(clk), .rst_n(rst_n), .start(start), .partial(partial),
      .cmpl_tmo_cyc(cmpl_tmo), .s_data(s_data), .s_valid(s_valid), .s_last(s_last),
      .s_ready(s_ready), .cfg_prog_n(cfg_prog_n), .cfg_init_n(init_n),
      .cfg_done(done_pin), .cfg_cclk(cfg_cclk), .cfg_din(cfg_din), .busy(busy),
      .done_ok(done_ok), .err_code(err_code), .err_init_rise(err_init_rise)
   );

   int n_cmp = 0, n_bad = 0;
   int cyc = 0, lat_mark = 0, rises = 0, nbit = 0, last_rise = 0, prog_falls = 0;
   int done_thr = 0;
   bit force_done = 0, never_low = 0, never_high = 0, allow_ff = 0;
   int lo_dly = 0, hi_dly = 0;
   logic [7:0] mon_sr = '0;
   logic [7:0] exp_q[$];

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   // target device model, driven away from the active edge
   always @(negedge clk) begin
      cyc <= cyc + 1;
      if (!cfg_prog_n) begin
         hi_dly <= 0;
         if (lo_dly < 5) lo_dly <= lo_dly + 1;
         else if (!never_low) init_n <= 1'b0;
      end else begin
         lo_dly <= 0;
         if (!init_n && !never_high) begin
            if (hi_dly < 5) hi_dly <= hi_dly + 1;
            else begin
               init_n   <= 1'b1;
               lat_mark <= cyc;
            end
         end
      end
      done_pin <= force_done || (done_thr != 0 && rises >= done_thr);
   end

   always @(negedge cfg_prog_n) prog_falls++;

   // monitor / scoreboard on the serial link
   always @(posedge cfg_cclk) begin
      mon_sr = {mon_sr[6:0], cfg_din};
      nbit++;
      rises++;
      if (rises == 1)
         check(cyc - lat_mark >= LAT, "R6 latency", cyc - lat_mark, LAT);
      else if (nbit > 1)
         check(cyc - last_rise == 2 * DIV, "R7 clock period", cyc - last_rise, 2 * DIV);
      last_rise = cyc;
      if (nbit == 8) begin
         nbit = 0;
         if (exp_q.size() > 0) begin
            logic [7:0] e;
            e = exp_q.pop_front();
            check(mon_sr == e, "R7/R9 byte", mon_sr, e);
         end else if (allow_ff) begin
            check(mon_sr == 8'hFF, "R10 trailer byte", mon_sr, 8'hFF);
         end else begin
            check(1'b0, "R8/R9 unexpected byte", mon_sr, -1);
         end
      end
   end

   task automatic wait_idle();
      for (int t = 0; t < 20000; t++) begin
         @(negedge clk);
         if (!busy) return;
      end
      check(1'b0, "R11 load never ended", 1, 0);
   endtask

   task automatic run_load(input int nb, input int base, input bit part, input int ntr,
                           input bit poke);
      int idx;
      rises = 0; nbit = 0; prog_falls = 0;
      for (int k = 0; k < nb; k++) exp_q.push_back(8'(base + k * 37));
      for (int k = 0; k < ntr; k++) exp_q.push_back(8'hFF);
      @(negedge clk);
      start = 1'b1; partial = part;
      @(negedge clk);
      start = 1'b0; partial = 1'b0;
      idx = 0;
      if (nb > 0) begin
         s_valid = 1'b1; s_data = 8'(base); s_last = (nb == 1);
      end
      for (int t = 0; t < 20000 && busy; t++) begin
         bit took;
         took = s_valid && s_ready;
         if (poke && t == 10) start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         if (took) begin
            idx++;
            if (idx < nb) begin
               s_data = 8'(base + idx * 37); s_last = (idx == nb - 1);
            end else begin
               s_valid = 1'b0; s_last = 1'b0;
            end
         end
      end
      s_valid = 1'b0; s_last = 1'b0;
      wait_idle();
      repeat (2) @(negedge clk);
   endtask

   task automatic settle();
      force_done = 0; never_low = 0; never_high = 0; allow_ff = 0; done_thr = 0;
      exp_q.delete();
      repeat (20) @(negedge clk);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(cfg_prog_n == 1'b1, "R1 prog_n", cfg_prog_n, 1);
      check(cfg_cclk == 1'b0, "R1 cclk", cfg_cclk, 0);
      check(s_ready == 1'b0, "R1 s_ready", s_ready, 0);
      check(busy == 1'b0 && done_ok == 1'b0, "R1 busy/done_ok", {busy, done_ok}, 0);
      check(err_code == 2'd0, "R1 err_code", err_code, 0);

      // R2 partial request refused
      run_load(0, 0, 1'b1, 0, 1'b0);
      check(err_code == 2'd3, "R2 err_code", err_code, 3);
      check(prog_falls == 0, "R2 program untouched", prog_falls, 0);
      check(busy == 1'b0, "R2 busy", busy, 0);

      // R8 done rises with the last data bit: one trailer. R11 start while busy ignored.
      settle(); done_thr = 24;
      run_load(3, 8'h5A, 1'b0, 1, 1'b1);
      check(done_ok == 1'b1 && err_code == 2'd0, "R8 success", {done_ok, err_code}, 4);
      check(exp_q.size() == 0, "R8 all bytes seen", exp_q.size(), 0);
      check(rises == 32, "R8 clock count", rises, 32);
      check(prog_falls == 1, "R11 start while busy ignored", prog_falls, 1);

      // R9 done rises after three trailers: four trailers in all
      settle(); done_thr = 40;
      run_load(2, 8'h81, 1'b0, 4, 1'b0);
      check(done_ok == 1'b1 && err_code == 2'd0, "R9 success", {done_ok, err_code}, 4);
      check(exp_q.size() == 0, "R9 all bytes seen", exp_q.size(), 0);
      check(rises == 48, "R9 clock count", rises, 48);

      // R10 done never rises
      settle(); cmpl_tmo = 32'd150; allow_ff = 1;
      run_load(2, 8'h13, 1'b0, 0, 1'b0);
      check(err_code == 2'd1 && err_init_rise == 1'b0, "R10 timeout", {err_code, err_init_rise}, 2);
      check(done_ok == 1'b0, "R10 no success", done_ok, 0);
      check(rises > 16, "R10 trailers sent", rises, 17);
      cmpl_tmo = 32'd5000;
      // R11 status held while idle
      repeat (50) @(negedge clk);
      check(err_code == 2'd1, "R11 code held", err_code, 1);

      // R5 done high before data
      settle(); force_done = 1;
      run_load(2, 8'h22, 1'b0, 0, 1'b0);
      check(err_code == 2'd2, "R5 io error", err_code, 2);
      check(rises == 0, "R5 no clocks", rises, 0);
      check(cfg_prog_n == 1'b1, "R5 prog released", cfg_prog_n, 1);

      // R3 init never goes low
      settle(); never_low = 1;
      run_load(0, 0, 1'b0, 0, 1'b0);
      check(err_code == 2'd1 && err_init_rise == 1'b0, "R3 timeout", {err_code, err_init_rise}, 2);
      check(cfg_prog_n == 1'b1, "R3 prog released", cfg_prog_n, 1);
      check(prog_falls == 1, "R3 program pulsed", prog_falls, 1);

      // R4 init never returns high
      settle(); never_high = 1;
      run_load(0, 0, 1'b0, 0, 1'b0);
      check(err_code == 2'd1 && err_init_rise == 1'b1, "R4 rise timeout", {err_code, err_init_rise}, 3);
      check(rises == 0, "R4 no clocks", rises, 0);

      // R12 one byte per handshake; single byte with s_last on it
      settle(); done_thr = 8;
      run_load(1, 8'hC3, 1'b0, 1, 1'b0);
      check(done_ok == 1'b1 && exp_q.size() == 0, "R12 single byte load", {done_ok, 8'(exp_q.size())}, 256);
      check(rises == 16, "R12 clock count", rises, 16);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      check(1'b0, "watchdog", cyc, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule